// File: doc/BRIEF.md
# Byte-Bus to PCI Single-Cycle Bridge

This bridge lets an 8-bit microcontroller reach one 32-bit PCI target. To the controller, the bridge looks like external memory.

The controller side has four parts:
- a multiplexed address/data byte port;
- a separate port for the high address byte;
- an address latch strobe;
- active-low read and write strobes.

Software prepares a transaction in byte-wide registers: four outbound bytes that form the 32-bit address/data word, and one command/byte-enable byte. Writing the command byte starts exactly one PCI transaction. That transaction has a single address phase followed by a single data phase.

On a read, the bridge lands the four bytes returned by the target in four inbound registers. Software polls a status byte, then fetches the inbound bytes.

A reset register drives the target's hardware reset line. A configuration access raises IDSEL, and only a configuration access does. The bridge derives this purely from the command code. I/O accesses whose low address bits do not match the lowest enabled byte lane are refused before any bus activity.

The controller strobes are treated as synchronous to the bridge clock; any synchronisation happens outside the block. The bidirectional byte bus and the PCI AD bus are each split into an input, an output and an output enable. The pad tristate is left to the chip top.

Top module: `bytebus_pci_bridge`

## Requirements
- R1: The low address byte is captured from `mcu_ad_i` on the clock where `mcu_ale` is seen falling. The high byte is taken live from `mcu_ahi`. A register is selected only when the high byte equals `BASE_PAGE` (default 0x80) and the low byte is 0 to 10. An unselected read leaves `mcu_ad_oe` low. An unselected write changes no register.
- R2: A write strobe (the falling edge of `mcu_wr_n`, data on `mcu_ad_i`) to offset k (0..3) stores lane k of the outbound word, bits 8k+7..8k. The outbound lanes can be read back at the same offsets while `mcu_rd_n` is low.
- R3: Writing offset 8 while idle starts a transaction. The byte's bits 7..4 are the command and bits 3..0 are the active-low byte enables. On the next clock, FRAME# is low for exactly one clock, with the outbound word on `pci_ad_o` (`pci_ad_oe`=1) and the command on `pci_cbe_n`.
- R4: IDSEL is high during the address phase only when command bit 3 is 1 (configuration). It stays low for I/O commands and in every other cycle.
- R5: In the clock after the address phase, FRAME# is high, IRDY# is low and `pci_cbe_n` carries the byte enables. Write commands (command bit 0 = 1) keep driving the outbound word. Read commands drop `pci_ad_oe`.
- R6: The data phase completes on the first rising edge with TRDY# low. IRDY# is high in the following clock. For a read, `pci_ad_i` lane k is captured into inbound offset 4+k at that edge.
- R7: Status at offset 10 has three flags: bit 0 busy, bit 1 timeout, bit 2 reject. Busy reads 1 from the clock after the starting write until the completing edge. Every start attempt clears both the timeout and reject flags.
- R8: If TRDY# stays high for 16 data-phase clocks, IRDY# is released, the timeout flag is set and the bridge returns to idle. The inbound registers keep their previous contents.
- R9: A start is rejected in any of three cases:
  - the command is not 1010, 1011, 0010 or 0011;
  - it is an I/O command with no byte enabled;
  - it is an I/O command whose lowest enabled lane index differs from outbound bits 1..0.

  A byte-enable bit of 0 means the lane is enabled. A rejected start causes no FRAME# and sets the reject flag.
- R10: While busy, writes to offsets 0..3 and 8 are ignored.
- R11: Offset 9 bit 0 holds the target in reset: `pci_rst_n` is its inverse. The bit reads back at offset 9 and is 1 after bridge reset.
- R12: During and after reset, FRAME# and IRDY# are high, `pci_ad_oe` and `pci_idsel` are 0, and the status reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge and PCI clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mcu_ale | input | 1 | Address latch strobe, low byte taken on its fall |
| mcu_rd_n | input | 1 | Active-low read strobe |
| mcu_wr_n | input | 1 | Active-low write strobe |
| mcu_ahi | input | 8 | High address byte |
| mcu_ad_i | input | 8 | Multiplexed address/data byte, inbound |
| mcu_ad_o | output | 8 | Read data toward the controller |
| mcu_ad_oe | output | 1 | Enable for `mcu_ad_o` |
| pci_ad_i | input | 32 | AD bus as seen from the target |
| pci_ad_o | output | 32 | AD bus driven by the bridge |
| pci_ad_oe | output | 1 | Enable for `pci_ad_o` |
| pci_cbe_n | output | 4 | Command in address phase, byte enables in data phase |
| pci_frame_n | output | 1 | Active-low FRAME |
| pci_irdy_n | output | 1 | Active-low initiator ready |
| pci_trdy_n | input | 1 | Active-low target ready |
| pci_idsel | output | 1 | Configuration select |
| pci_rst_n | output | 1 | Active-low target reset |

## Verification
Most internal faults surface on the PCI pins within one or two clocks of the starting write, because FRAME#, IDSEL, C/BE# and the AD enable decode the sequencer state directly:
- a stuck sequencer state shows as FRAME# lasting more than one clock, or as IRDY# never rising;
- a wrong command decode shows as IDSEL high during I/O;
- an error in the lane check shows as FRAME# appearing for a refused access, or missing for a legal one.

Faults in the wait counter show as IRDY# released a clock early or late relative to the sixteenth data clock. Faults in the capture path show only later, when software reads the inbound or status offsets back through the byte port.

// File: rtl/bridge_pkg.sv
// Package bridge_pkg
// Shared types, register offsets and command decoding for the byte-bus
// to PCI bridge. Assumes a single bridge clock for both sides.
package bridge_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ADDR = 2'd1,
        SEQ_DATA = 2'd2
    } seq_state_t;

    localparam int unsigned LANES  = 4;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned WORD_W = LANES * BYTE_W;

    localparam logic [7:0] OFS_OUT0 = 8'd0;
    localparam logic [7:0] OFS_IN0  = 8'd4;
    localparam logic [7:0] OFS_CMD  = 8'd8;
    localparam logic [7:0] OFS_HOLD = 8'd9;
    localparam logic [7:0] OFS_STAT = 8'd10;

    localparam logic [3:0] CMD_CFG_RD = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR = 4'b1011;
    localparam logic [3:0] CMD_IO_RD  = 4'b0010;
    localparam logic [3:0] CMD_IO_WR  = 4'b0011;

    // True for the four command codes the bridge can issue.
    function automatic logic cmd_supported(input logic [3:0] c);
        return (c == CMD_CFG_RD) || (c == CMD_CFG_WR) ||
               (c == CMD_IO_RD)  || (c == CMD_IO_WR);
    endfunction

    // Returns {found, index} of the lowest enabled lane (enable is active low).
    function automatic logic [2:0] lowest_lane(input logic [3:0] be_n);
        logic [2:0] r;
        r = 3'b000;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (!be_n[i]) r = {1'b1, 2'(i)};
        end
        return r;
    endfunction

endpackage

// File: rtl/mcu_strobe.sv
// Module mcu_strobe
// Detects the controller's strobe edges and latches the low address byte
// when the address latch strobe falls. Assumes strobes are already
// synchronous to clk and each strobe lasts at least one clock.
module mcu_strobe #(
    parameter int unsigned AW_HALF = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ale,
    input  logic                 rd_n,
    input  logic                 wr_n,
    input  logic [AW_HALF-1:0]   ad_i,
    input  logic [AW_HALF-1:0]   ahi,
    output logic [2*AW_HALF-1:0] addr,
    output logic                 wr_pulse,
    output logic                 rd_active
);
    logic               ale_q;
    logic               wr_n_q;
    logic [AW_HALF-1:0] addr_lo;

    // Previous strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ale_q  <= 1'b0;
            wr_n_q <= 1'b1;
        end else begin
            ale_q  <= ale;
            wr_n_q <= wr_n;
        end
    end

    // Low address byte taken when the latch strobe falls.
    always_ff @(posedge clk) begin
        if (!rst_n)               addr_lo <= '0;
        else if (ale_q && !ale)   addr_lo <= ad_i;
    end

    // Address, write pulse and read window toward the register bank.
    always_comb begin
        addr      = {ahi, addr_lo};
        wr_pulse  = wr_n_q && !wr_n;
        rd_active = !rd_n && !ale;
    end
endmodule

// File: rtl/bridge_regs.sv
// Module bridge_regs
// Byte-wide register bank: outbound lanes, target reset hold bit and the
// read-back multiplexer. Assumes addr is stable while the strobe is active.
module bridge_regs
    import bridge_pkg::*;
#(
    parameter logic [7:0] BASE_PAGE = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       addr,
    input  logic              wr_pulse,
    input  logic [7:0]        wdata,
    input  logic              rd_active,
    input  logic              busy,
    input  logic [WORD_W-1:0] in_word,
    input  logic [7:0]        cmd_byte,
    input  logic [7:0]        status,
    output logic [WORD_W-1:0] out_word,
    output logic              hold_rst,
    output logic              cmd_wr,
    output logic [7:0]        rd_data,
    output logic              rd_oe
);
    logic       sel;
    logic [7:0] ofs;

    // Page match and offset range decode.
    always_comb begin
        ofs = addr[7:0];
        sel = (addr[15:8] == BASE_PAGE) && (ofs <= OFS_STAT);
    end

    // One writable register per outbound lane, frozen while busy.
    for (genvar k = 0; k < LANES; k++) begin : g_out_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                out_word[k*BYTE_W +: BYTE_W] <= '0;
            else if (wr_pulse && sel && !busy && ofs == OFS_OUT0 + 8'(k))
                out_word[k*BYTE_W +: BYTE_W] <= wdata;
        end
    end

    // Target reset hold bit, asserted out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 hold_rst <= 1'b1;
        else if (wr_pulse && sel && ofs == OFS_HOLD) hold_rst <= wdata[0];
    end

    // Start request to the sequencer.
    always_comb cmd_wr = wr_pulse && sel && !busy && (ofs == OFS_CMD);

    // Read-back multiplexer.
    always_comb begin
        rd_oe   = rd_active && sel;
        rd_data = 8'h00;
        if (ofs < OFS_IN0)        rd_data = out_word[ofs[1:0]*BYTE_W +: BYTE_W];
        else if (ofs < OFS_CMD)   rd_data = in_word[ofs[1:0]*BYTE_W +: BYTE_W];
        else if (ofs == OFS_CMD)  rd_data = cmd_byte;
        else if (ofs == OFS_HOLD) rd_data = {7'b0, hold_rst};
        else                      rd_data = status;
    end

    // R10: outbound word cannot change while a transaction is under way.
    assert_busy_freezes_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(out_word));
endmodule

// File: rtl/pci_seq.sv
// Module pci_seq
// One-shot PCI initiator: checks a start request, runs one address phase
// and one data phase, waits for target ready with a bounded counter and
// captures read data. Assumes one target, no bursts, no arbitration.
module pci_seq
    import bridge_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        start_byte,
    input  logic [WORD_W-1:0] out_word,
    input  logic [WORD_W-1:0] pci_ad_i,
    input  logic              pci_trdy_n,
    output logic [WORD_W-1:0] pci_ad_o,
    output logic              pci_ad_oe,
    output logic [3:0]        pci_cbe_n,
    output logic              pci_frame_n,
    output logic              pci_irdy_n,
    output logic              pci_idsel,
    output logic [WORD_W-1:0] in_word,
    output logic [7:0]        cmd_q,
    output logic              busy,
    output logic              timeout_flag,
    output logic              reject_flag
);
    localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1);

    seq_state_t state;
    logic [CNT_W-1:0] wait_cnt;
    logic [2:0]       lane;
    logic             legal;
    logic             done;
    logic             expire;

    // Legality of the requested command and lane alignment.
    always_comb begin
        lane  = lowest_lane(start_byte[3:0]);
        legal = cmd_supported(start_byte[7:4]) &&
                (start_byte[7] || (lane[2] && lane[1:0] == out_word[1:0]));
        done   = (state == SEQ_DATA) && !pci_trdy_n;
        expire = (state == SEQ_DATA) && pci_trdy_n &&
                 (wait_cnt == CNT_W'(TIMEOUT_CYC - 1));
    end

    // Phase sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
        end else begin
            case (state)
                SEQ_IDLE: if (start && legal) state <= SEQ_ADDR;
                SEQ_ADDR: state <= SEQ_DATA;
                SEQ_DATA: if (done || expire) state <= SEQ_IDLE;
                default:  state <= SEQ_IDLE;
            endcase
        end
    end

    // Command latch and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q        <= 8'h00;
            timeout_flag <= 1'b0;
            reject_flag  <= 1'b0;
        end else if (start && state == SEQ_IDLE) begin
            timeout_flag <= 1'b0;
            reject_flag  <= !legal;
            if (legal) cmd_q <= start_byte;
        end else if (expire) begin
            timeout_flag <= 1'b1;
        end
    end

    // Wait counter for target ready during the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n || state != SEQ_DATA) wait_cnt <= '0;
        else                             wait_cnt <= wait_cnt + 1'b1;
    end

    // Inbound capture on the completing edge of a read.
    always_ff @(posedge clk) begin
        if (!rst_n)                   in_word <= '0;
        else if (done && !cmd_q[4])   in_word <= pci_ad_i;
    end

    // Bus outputs decoded from the registered phase.
    always_comb begin
        busy        = (state != SEQ_IDLE);
        pci_frame_n = (state != SEQ_ADDR);
        pci_irdy_n  = (state != SEQ_DATA);
        pci_idsel   = (state == SEQ_ADDR) && cmd_q[7];
        pci_ad_o    = out_word;
        pci_ad_oe   = (state == SEQ_ADDR) || ((state == SEQ_DATA) && cmd_q[4]);
        case (state)
            SEQ_ADDR: pci_cbe_n = cmd_q[7:4];
            SEQ_DATA: pci_cbe_n = cmd_q[3:0];
            default:  pci_cbe_n = 4'hF;
        endcase
    end

    // R3: address phase lasts a single clock.
    assert_frame_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pci_frame_n |=> pci_frame_n);
    // R5: data phase follows the address phase at once.
    assert_irdy_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !pci_frame_n |=> !pci_irdy_n);
    // R4: configuration select only with a configuration command on C/BE.
    assert_idsel_cfg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pci_idsel |-> (!pci_frame_n && pci_cbe_n[3]));
    // R6: target ready ends the data phase.
    assert_release_after_trdy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pci_irdy_n && !pci_trdy_n) |=> pci_irdy_n);
    // R8: an expired wait releases IRDY and flags the timeout.
    assert_timeout_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pci_irdy_n && pci_trdy_n && wait_cnt == CNT_W'(TIMEOUT_CYC - 1))
        |=> (pci_irdy_n && timeout_flag));
    // R5: reads never drive AD during the data phase.
    assert_read_floats_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pci_irdy_n && !pci_cbe_n[0] && !cmd_q[4]) |-> !pci_ad_oe);
endmodule

// File: rtl/bytebus_pci_bridge.sv
// Module bytebus_pci_bridge
// Top of the byte-bus to PCI bridge: strobe front end, register bank and
// single-transaction PCI sequencer. Assumes a single clock and one target.
module bytebus_pci_bridge
    import bridge_pkg::*;
#(
    parameter logic [7:0]  BASE_PAGE   = 8'h80,
    parameter int unsigned TIMEOUT_CYC = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mcu_ale,
    input  logic        mcu_rd_n,
    input  logic        mcu_wr_n,
    input  logic [7:0]  mcu_ahi,
    input  logic [7:0]  mcu_ad_i,
    output logic [7:0]  mcu_ad_o,
    output logic        mcu_ad_oe,
    input  logic [31:0] pci_ad_i,
    output logic [31:0] pci_ad_o,
    output logic        pci_ad_oe,
    output logic [3:0]  pci_cbe_n,
    output logic        pci_frame_n,
    output logic        pci_irdy_n,
    input  logic        pci_trdy_n,
    output logic        pci_idsel,
    output logic        pci_rst_n
);
    logic [15:0]       addr;
    logic              wr_pulse;
    logic              rd_active;
    logic [WORD_W-1:0] out_word;
    logic [WORD_W-1:0] in_word;
    logic [7:0]        cmd_q;
    logic              busy;
    logic              timeout_flag;
    logic              reject_flag;
    logic              hold_rst;
    logic              cmd_wr;
    logic [7:0]        status;

    mcu_strobe #(.AW_HALF(8)) u_strobe (
        .clk(clk), .rst_n(rst_n), .ale(mcu_ale), .rd_n(mcu_rd_n),
        .wr_n(mcu_wr_n), .ad_i(mcu_ad_i), .ahi(mcu_ahi), .addr(addr),
        .wr_pulse(wr_pulse), .rd_active(rd_active)
    );

    // Status byte assembled from sequencer flags.
    always_comb status = {5'b0, reject_flag, timeout_flag, busy};

    bridge_regs #(.BASE_PAGE(BASE_PAGE)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_pulse(wr_pulse),
        .wdata(mcu_ad_i), .rd_active(rd_active), .busy(busy),
        .in_word(in_word), .cmd_byte(cmd_q), .status(status),
        .out_word(out_word), .hold_rst(hold_rst), .cmd_wr(cmd_wr),
        .rd_data(mcu_ad_o), .rd_oe(mcu_ad_oe)
    );

    pci_seq #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(cmd_wr), .start_byte(mcu_ad_i),
        .out_word(out_word), .pci_ad_i(pci_ad_i), .pci_trdy_n(pci_trdy_n),
        .pci_ad_o(pci_ad_o), .pci_ad_oe(pci_ad_oe), .pci_cbe_n(pci_cbe_n),
        .pci_frame_n(pci_frame_n), .pci_irdy_n(pci_irdy_n),
        .pci_idsel(pci_idsel), .in_word(in_word), .cmd_q(cmd_q),
        .busy(busy), .timeout_flag(timeout_flag), .reject_flag(reject_flag)
    );

    // Target reset follows the hold bit.
    always_comb pci_rst_n = !hold_rst;

    // R11: target reset line mirrors the hold bit.
    assert_target_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_rst) |-> pci_rst_n);
endmodule

// File: tb/tb_bytebus_pci_bridge.sv
// Directed bench for bytebus_pci_bridge: one task per scenario.
module tb_bytebus_pci_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mcu_ale = 1'b0, mcu_rd_n = 1'b1, mcu_wr_n = 1'b1;
    logic [7:0]  mcu_ahi = 8'h00, mcu_ad_i = 8'h00;
    logic [7:0]  mcu_ad_o;
    logic        mcu_ad_oe;
    logic [31:0] pci_ad_i = 32'h0;
    logic [31:0] pci_ad_o;
    logic        pci_ad_oe;
    logic [3:0]  pci_cbe_n;
    logic        pci_frame_n, pci_irdy_n, pci_idsel, pci_rst_n;
    logic        pci_trdy_n = 1'b1;
    int          n_chk = 0, n_err = 0;

    always #2 clk = ~clk;

    bytebus_pci_bridge dut (
        .clk(clk), .rst_n(rst_n), .mcu_ale(mcu_ale), .mcu_rd_n(mcu_rd_n),
        .mcu_wr_n(mcu_wr_n), .mcu_ahi(mcu_ahi), .mcu_ad_i(mcu_ad_i),
        .mcu_ad_o(mcu_ad_o), .mcu_ad_oe(mcu_ad_oe), .pci_ad_i(pci_ad_i),
        .pci_ad_o(pci_ad_o), .pci_ad_oe(pci_ad_oe), .pci_cbe_n(pci_cbe_n),
        .pci_frame_n(pci_frame_n), .pci_irdy_n(pci_irdy_n),
        .pci_trdy_n(pci_trdy_n), .pci_idsel(pci_idsel), .pci_rst_n(pci_rst_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic mcu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); mcu_ahi = a[15:8]; mcu_ad_i = a[7:0]; mcu_ale = 1'b1;
        @(negedge clk); mcu_ale = 1'b0;
        @(negedge clk); mcu_ad_i = d; mcu_wr_n = 1'b0;
        @(negedge clk); mcu_wr_n = 1'b1;
    endtask

    task automatic mcu_read(input logic [15:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk); mcu_ahi = a[15:8]; mcu_ad_i = a[7:0]; mcu_ale = 1'b1;
        @(negedge clk); mcu_ale = 1'b0;
        @(negedge clk); mcu_rd_n = 1'b0;
        @(negedge clk); d = mcu_ad_o; oe = mcu_ad_oe; mcu_rd_n = 1'b1;
    endtask

    task automatic test_reset();
        logic [7:0] d; logic oe;
        chk("R12 frame idle", {31'b0, pci_frame_n}, 32'd1);
        chk("R12 irdy idle", {31'b0, pci_irdy_n}, 32'd1);
        chk("R12 ad_oe idle", {31'b0, pci_ad_oe}, 32'd0);
        chk("R12 idsel idle", {31'b0, pci_idsel}, 32'd0);
        chk("R11 target held in reset", {31'b0, pci_rst_n}, 32'd0);
        mcu_read(16'h800A, d, oe);
        chk("R12 status after reset", {24'b0, d}, 32'h00);
    endtask

    task automatic test_decode();
        logic [7:0] d; logic oe;
        mcu_write(16'h8000, 8'h04); mcu_write(16'h8001, 8'h22);
        mcu_write(16'h8002, 8'h33); mcu_write(16'h8003, 8'h44);
        mcu_read(16'h8001, d, oe);
        chk("R2 lane1 readback", {23'b0, oe, d}, {23'b0, 1'b1, 8'h22});
        mcu_write(16'h1201, 8'h99);
        mcu_read(16'h8001, d, oe);
        chk("R1 wrong page write ignored", {24'b0, d}, 32'h22);
        mcu_read(16'h1201, d, oe);
        chk("R1 wrong page read not driven", {31'b0, oe}, 32'd0);
        mcu_read(16'h800B, d, oe);
        chk("R1 offset 11 not driven", {31'b0, oe}, 32'd0);
    endtask

    task automatic test_hold_reg();
        logic [7:0] d; logic oe;
        mcu_read(16'h8009, d, oe);
        chk("R11 hold bit after reset", {24'b0, d}, 32'h01);
        mcu_write(16'h8009, 8'h00);
        chk("R11 target released", {31'b0, pci_rst_n}, 32'd1);
        mcu_read(16'h8009, d, oe);
        chk("R11 hold bit readback", {24'b0, d}, 32'h00);
    endtask

    task automatic test_io_write();
        logic [7:0] d; logic oe;
        mcu_write(16'h8008, 8'h3E);
        chk("R3 frame in address phase", {31'b0, pci_frame_n}, 32'd0);
        chk("R3 address on AD", pci_ad_o, 32'h44332204);
        chk("R3 command on CBE", {28'b0, pci_cbe_n}, 32'h3);
        chk("R3 AD driven", {31'b0, pci_ad_oe}, 32'd1);
        chk("R4 no idsel for IO", {31'b0, pci_idsel}, 32'd0);
        @(negedge clk);
        chk("R5 frame released", {31'b0, pci_frame_n}, 32'd1);
        chk("R5 irdy asserted", {31'b0, pci_irdy_n}, 32'd0);
        chk("R5 byte enables", {28'b0, pci_cbe_n}, 32'hE);
        chk("R5 write drives data", {31'b0, pci_ad_oe}, 32'd1);
        pci_trdy_n = 1'b0;
        @(negedge clk);
        pci_trdy_n = 1'b1;
        chk("R6 irdy released after trdy", {31'b0, pci_irdy_n}, 32'd1);
        mcu_read(16'h800A, d, oe);
        chk("R7 status idle after write", {24'b0, d}, 32'h00);
    endtask

    task automatic test_cfg_read();
        logic [7:0] d; logic oe;
        mcu_write(16'h8008, 8'hA0);
        chk("R4 idsel for configuration", {31'b0, pci_idsel}, 32'd1);
        chk("R3 config command", {28'b0, pci_cbe_n}, 32'hA);
        @(negedge clk);
        chk("R4 idsel only in address phase", {31'b0, pci_idsel}, 32'd0);
        chk("R5 read floats AD", {31'b0, pci_ad_oe}, 32'd0);
        mcu_read(16'h800A, d, oe);
        chk("R7 busy during data phase", {24'b0, d}, 32'h01);
        mcu_write(16'h8000, 8'hFF);
        pci_ad_i = 32'hDEADBEEF;
        pci_trdy_n = 1'b0;
        @(negedge clk);
        pci_trdy_n = 1'b1;
        chk("R6 read completes", {31'b0, pci_irdy_n}, 32'd1);
        for (int k = 0; k < 4; k++) begin
            mcu_read(16'h8004 + 16'(k), d, oe);
            chk("R6 inbound lane", {24'b0, d}, {24'b0, 8'(32'hDEADBEEF >> (8 * k))});
        end
        mcu_read(16'h8000, d, oe);
        chk("R10 write while busy ignored", {24'b0, d}, 32'h04);
        mcu_read(16'h8008, d, oe);
        chk("R3 command byte readback", {24'b0, d}, 32'hA0);
    endtask

    task automatic test_timeout();
        logic [7:0] d; logic oe;
        pci_ad_i = 32'h11111111;
        mcu_write(16'h8008, 8'h2E);
        repeat (16) @(negedge clk);
        chk("R8 still waiting at 16th data clock", {31'b0, pci_irdy_n}, 32'd0);
        @(negedge clk);
        chk("R8 irdy released after 16 clocks", {31'b0, pci_irdy_n}, 32'd1);
        mcu_read(16'h800A, d, oe);
        chk("R8 timeout flag", {24'b0, d}, 32'h02);
        mcu_read(16'h8004, d, oe);
        chk("R8 inbound unchanged", {24'b0, d}, 32'hEF);
    endtask

    task automatic test_reject();
        logic [7:0] d; logic oe;
        mcu_write(16'h8000, 8'h05);
        mcu_write(16'h8008, 8'h3B);
        chk("R9 lane mismatch gives no frame", {31'b0, pci_frame_n}, 32'd1);
        mcu_read(16'h800A, d, oe);
        chk("R9 reject flag, timeout cleared R7", {24'b0, d}, 32'h04);
        mcu_write(16'h8008, 8'h3F);
        chk("R9 no lane gives no frame", {31'b0, pci_frame_n}, 32'd1);
        mcu_write(16'h8008, 8'h6E);
        chk("R9 unsupported command gives no frame", {31'b0, pci_frame_n}, 32'd1);
        mcu_write(16'h8008, 8'h3D);
        chk("R9 aligned lane accepted", {31'b0, pci_frame_n}, 32'd0);
        @(negedge clk);
        pci_trdy_n = 1'b0;
        @(negedge clk);
        pci_trdy_n = 1'b1;
        mcu_read(16'h800A, d, oe);
        chk("R7 flags cleared by accepted start", {24'b0, d}, 32'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_decode();
        test_hold_reg();
        test_io_write();
        test_cfg_read();
        test_timeout();
        test_reject();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule